// File: doc/BRIEF.md
# Selectable Clock Output Divider

This block drives one clock-output pin from one of three on-chip clocks: a low-speed internal oscillator, a high-speed oscillator, or the system clock. A single 16-bit control word, written from the bus clock domain, turns the output on, picks the source and picks a power-of-two division ratio. The two oscillators can be divided by 1 to 128. The system clock can only be passed through undivided. While the device sleeps or halts, the system-clock source stops. Any combination that is not supported holds the pin low.

Each source clock has its own lane, and that lane builds the divided waveform in its own clock domain. A lane picks up a new setting only at the end of a whole output period, after its last high phase has finished. A lane starts only once every other lane has gone idle. Because of this, switching the source, changing the ratio, disabling or enabling the output never produces a shortened pulse. The output always begins with a full-length low phase.

Top module: `clkout_divsel`

## Requirements
- R1: The control word has the enable in bit 0, the source code in bits 3:2 and the divide code in bits 6:4. Every other bit ignores writes and reads as 0. After reset the word reads 0x0000.
- R2: After reset, and whenever bit 0 is 0, the output stays low. When the output is enabled again, it starts with a low phase of full length.
- R3: Source code 0 selects the internal oscillator, code 2 selects the high-speed oscillator and code 3 selects the system clock. The output waveform is timed by the selected source.
- R4: For the oscillator sources, divide code c from 0 to 6 gives a ratio of 1/2^(7-c). High and low phases each last 2^(6-c) source periods. Divide code 7 passes the source through unchanged.
- R5: Source code 1, or source code 3 with any divide code other than 7, drives the output low and keeps it low.
- R6: With the system clock selected, the output stays low while the sleep/halt input is high. Output resumes once the input is released.
- R7: A change of setting takes effect only after the current output period has ended low. No high pulse is shorter than a legal half period of some valid setting, and no low pulse is shorter than the shortest legal half period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Clock of the control-word write port |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word to write |
| rd_data | output | 16 | Stored control word, reserved bits as 0 |
| iosc_clk | input | 1 | Low-speed internal oscillator clock |
| osc3_clk | input | 1 | High-speed oscillator clock |
| sys_clk | input | 1 | System clock |
| sleep_mode | input | 1 | High while the device is in sleep or halt |
| clk_out | output | 1 | Clock-output pin signal |

## Verification
The internal-oscillator lane is run through all eight divide codes. The high-speed lane is tried at three codes. Each run measures the exact high and low widths, which separates every code from its neighbours and confirms that the 50% duty cycle holds. The source is moved between three clocks with distinct periods, so a wrong source mapping shows up as a wrong width. Reserved source codes, reserved system-clock ratios, sleep and disable each get a quiet window in which no rising edge may appear. Throughout the run, a pulse monitor checks every high pulse against the set of legal half periods, which catches runt pulses produced during switches.

// File: rtl/clkout_pkg.sv
`timescale 1ns/1ps
package clkout_pkg;
  localparam int DIV_W = 3;
  localparam int SRC_W = 2;
  localparam int NSRC  = 3;
  localparam int CNT_W = (1 << DIV_W) - 2;
  localparam logic [DIV_W-1:0] DIV_PASS = '1;
  localparam logic [15:0] REG_MASK = 16'h007D;

  // half period minus one, in source cycles, for a divide code
  function automatic logic [CNT_W-1:0] half_m1(input logic [DIV_W-1:0] code);
    if (code == DIV_PASS) return '0;
    return CNT_W'((1 << (CNT_W - int'(code))) - 1);
  endfunction

  // which lane a control setting asks for (none when reserved)
  function automatic logic [NSRC-1:0] lane_req(input logic en,
                                               input logic [SRC_W-1:0] sel,
                                               input logic [DIV_W-1:0] div);
    logic [NSRC-1:0] r;
    r = '0;
    if (en) begin
      case (sel)
        2'd0:    r[0] = 1'b1;
        2'd2:    r[1] = 1'b1;
        2'd3:    r[2] = (div == DIV_PASS);
        default: r = '0;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/clkout_sync.sv
`timescale 1ns/1ps
module clkout_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/clkout_regs.sv
`timescale 1ns/1ps
module clkout_regs
  import clkout_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [15:0]      wr_data,
  output logic [15:0]      rd_data,
  output logic [DIV_W-1:0] div_cfg,
  output logic [NSRC-1:0]  req
);
  logic             en_q;
  logic [SRC_W-1:0] sel_q;
  logic [DIV_W-1:0] div_q;
  logic [NSRC-1:0]  req_q;
  logic             unused_bits;

  assign unused_bits = ^{wr_data[15:7], wr_data[1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= '0;
      div_q <= '0;
      req_q <= '0;
    end else if (wr_en) begin
      en_q  <= wr_data[0];
      sel_q <= wr_data[3:2];
      div_q <= wr_data[6:4];
      req_q <= lane_req(wr_data[0], wr_data[3:2], wr_data[6:4]);
    end
  end

  assign rd_data = {9'b0, div_q, sel_q, 1'b0, en_q};
  assign div_cfg = div_q;
  assign req     = req_q;

  assert_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == ($past(wr_data) & REG_MASK));
endmodule

// File: rtl/clkout_lane.sv
`timescale 1ns/1ps
module clkout_lane
  import clkout_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             lclk,
  input  logic             rst_n,
  input  logic             req_a,
  input  logic [DIV_W-1:0] div_a,
  input  logic             hold_a,
  input  logic             others_a,
  output logic             busy,
  output logic             lane_out
);
  localparam int SW = DIV_W + 3;

  logic [SW-1:0]    s_now, s_prev;
  logic             s_req, s_hold, s_others;
  logic [DIV_W-1:0] s_div;
  logic             cfg_ok, start, stop, bypass;
  logic             active, q, gate;
  logic [DIV_W-1:0] cur_div;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  clkout_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(lclk), .rst_n(rst_n),
    .d({req_a, hold_a, others_a, div_a}), .q(s_now));

  always_ff @(posedge lclk or negedge rst_n) begin
    if (!rst_n) s_prev <= '0;
    else        s_prev <= s_now;
  end

  assign {s_req, s_hold, s_others, s_div} = s_now;
  assign cfg_ok = (s_now == s_prev);
  assign start  = s_req && !s_hold && !s_others && cfg_ok;
  assign stop   = !s_req || s_hold || (s_div != cur_div);
  assign bypass = (cur_div == DIV_PASS);
  assign limit  = half_m1(cur_div);

  always_ff @(posedge lclk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      cur_div <= '0;
      cnt     <= '0;
      q       <= 1'b0;
    end else if (!active) begin
      if (start) begin
        active  <= 1'b1;
        cur_div <= s_div;
        cnt     <= '0;
        q       <= 1'b0;
      end
    end else if (bypass) begin
      if (stop) active <= 1'b0;
    end else if (cnt == limit) begin
      cnt <= '0;
      if (q) begin
        q <= 1'b0;
        if (stop) active <= 1'b0;
      end else begin
        q <= 1'b1;
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // pass-through gate moves only while the source clock is low
  always_ff @(negedge lclk or negedge rst_n) begin
    if (!rst_n) gate <= 1'b0;
    else        gate <= active && bypass;
  end

  assign busy     = active | gate;
  assign lane_out = bypass ? (lclk & gate) : q;

  assert_stop_low_R7: assert property (@(posedge lclk) disable iff (!rst_n)
    $fell(active) |-> !q);
  assert_div_frozen_R7: assert property (@(posedge lclk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(cur_div));
  assert_start_low_R2: assert property (@(posedge lclk) disable iff (!rst_n)
    $rose(active) |-> !q);
  assert_sleep_blocks_R6: assert property (@(posedge lclk) disable iff (!rst_n)
    (s_hold && !active) |=> !active);
endmodule

// File: rtl/clkout_divsel.sv
`timescale 1ns/1ps
module clkout_divsel
  import clkout_pkg::*;
(
  input  logic        bus_clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  input  logic        iosc_clk,
  input  logic        osc3_clk,
  input  logic        sys_clk,
  input  logic        sleep_mode,
  output logic        clk_out
);
  logic [DIV_W-1:0] div_cfg;
  logic [NSRC-1:0]  req;
  logic [NSRC-1:0]  src_clk;
  logic [NSRC-1:0]  hold;
  logic [NSRC-1:0]  busy;
  logic [NSRC-1:0]  lane_out;
  logic [DIV_W-1:0] lane_div [NSRC];

  assign src_clk = {sys_clk, osc3_clk, iosc_clk};
  assign hold    = {sleep_mode, 1'b0, 1'b0};

  clkout_regs u_regs (
    .clk(bus_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .div_cfg(div_cfg), .req(req));

  for (genvar i = 0; i < NSRC; i++) begin : g_lane
    logic others;
    assign others      = |(busy & ~(NSRC'(1) << i));
    assign lane_div[i] = (i == NSRC - 1) ? DIV_PASS : div_cfg;
    clkout_lane u_lane (
      .lclk(src_clk[i]), .rst_n(rst_n), .req_a(req[i]),
      .div_a(lane_div[i]), .hold_a(hold[i]), .others_a(others),
      .busy(busy[i]), .lane_out(lane_out[i]));
  end

  assign clk_out = |lane_out;

  assert_one_lane_R3: assert property (@(posedge bus_clk) disable iff (!rst_n)
    $onehot0(busy));
endmodule

// File: tb/sim_clkout_divsel.sv
`timescale 1ns/1ps
module sim_clkout_divsel;
  localparam int CLK_PERIOD = 10;
  localparam int T_IOSC = 40;
  localparam int T_OSC3 = 12;
  localparam int T_SYS  = 16;
  localparam int SETTLE = 12000;

  logic bus_clk = 0, iosc_clk = 0, osc3_clk = 0, sys_clk = 0;
  logic rst_n = 0, wr_en = 0, sleep_mode = 0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic clk_out;

  int n_tests = 0, n_fail = 0;
  int rise_cnt = 0, pulse_bad = 0;
  bit seen_rise = 0, seen_fall = 0;
  time t_rise = 0, t_fall = 0;

  always #(CLK_PERIOD/2) bus_clk  = ~bus_clk;
  always #(T_IOSC/2)     iosc_clk = ~iosc_clk;
  always #(T_OSC3/2)     osc3_clk = ~osc3_clk;
  always #(T_SYS/2)      sys_clk  = ~sys_clk;

  clkout_divsel u0 (
    .bus_clk(bus_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .iosc_clk(iosc_clk), .osc3_clk(osc3_clk),
    .sys_clk(sys_clk), .sleep_mode(sleep_mode), .clk_out(clk_out));

  // legal high widths: any half period of a valid setting
  function automatic bit legal_high(int w);
    if (w == T_IOSC/2 || w == T_OSC3/2 || w == T_SYS/2) return 1;
    for (int k = 0; k < 7; k++)
      if (w == (T_IOSC << k) || w == (T_OSC3 << k)) return 1;
    return 0;
  endfunction

  // expected half period for a divide code on an oscillator source
  function automatic int exp_half(int t_src, int code);
    if (code == 7) return t_src / 2;
    return t_src << (6 - code);
  endfunction

  always @(posedge clk_out) begin
    if (seen_fall && int'($time - t_fall) < T_OSC3/2) pulse_bad++;
    t_rise = $time;
    seen_rise = 1;
    rise_cnt++;
  end

  always @(negedge clk_out) begin
    if (seen_rise) begin
      if (!legal_high(int'($time - t_rise))) pulse_bad++;
      t_fall = $time;
      seen_fall = 1;
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] v);
    @(negedge bus_clk);
    wr_en = 1; wr_data = v;
    @(negedge bus_clk);
    wr_en = 0;
  endtask

  function automatic logic [15:0] cfg(int en, int src, int div);
    return 16'((div << 4) | (src << 2) | en);
  endfunction

  task automatic measure(output int hi, output int lo);
    time t0, t1, t2;
    @(posedge clk_out); t0 = $time;
    @(negedge clk_out); t1 = $time;
    @(posedge clk_out); t2 = $time;
    hi = int'(t1 - t0);
    lo = int'(t2 - t1);
  endtask

  task automatic run_div(int src, int t_src, int code, string tag);
    int hi, lo, e;
    wr(cfg(1, src, code));
    #(SETTLE);
    measure(hi, lo);
    e = exp_half(t_src, code);
    check(hi == e, tag, hi, e);
    check(lo == e, tag, lo, e);
  endtask

  task automatic quiet(int ns, string tag);
    int r0;
    r0 = rise_cnt;
    #(ns);
    check(rise_cnt == r0 && clk_out == 1'b0, tag, rise_cnt - r0, 0);
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int hi, lo;
    #95 rst_n = 1;
    #20;
    check(rd_data == 16'h0000, "R1 reset value", rd_data, 0);
    quiet(3000, "R2 low after reset");

    wr(16'h0082);
    check(rd_data == 16'h0000, "R1 reserved bits", rd_data, 0);
    wr(16'hFFFF);
    check(rd_data == 16'h007D, "R1 field readback", rd_data, 16'h7D);

    for (int c = 0; c < 8; c++) run_div(0, T_IOSC, c, $sformatf("R4 iosc code %0d", c));
    run_div(2, T_OSC3, 0, "R3 osc3 code 0");
    run_div(2, T_OSC3, 3, "R4 osc3 code 3");
    run_div(2, T_OSC3, 7, "R4 osc3 pass");
    run_div(3, T_SYS, 7, "R3 sys pass");

    sleep_mode = 1;
    #2000;
    quiet(3000, "R6 sleep stops sys");
    sleep_mode = 0;
    #2000;
    measure(hi, lo);
    check(hi == T_SYS/2 && lo == T_SYS/2, "R6 resume after sleep", hi, T_SYS/2);

    wr(cfg(1, 3, 2));
    #(SETTLE);
    quiet(3000, "R5 sys reserved divide");
    wr(cfg(1, 1, 3));
    #(SETTLE);
    quiet(3000, "R5 reserved source");

    wr(cfg(0, 0, 6));
    #(SETTLE);
    quiet(3000, "R2 disabled low");
    wr(cfg(1, 0, 6));
    #(SETTLE);
    measure(hi, lo);
    check(hi == 2*T_IOSC/2 && lo == T_IOSC, "R2 restart after enable", hi, T_IOSC);
    wr(cfg(0, 0, 6));
    #(SETTLE);
    quiet(3000, "R2 disable again");

    check(pulse_bad == 0, "R7 no runt pulses", pulse_bad, 0);
    check(rise_cnt > 0, "R7 pulses observed", rise_cnt, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule